// File: doc/BRIEF.md
# Synchronous 16-bit Serial Transceiver

This block moves 16-bit words over a serial data line and a shift clock. It has a transmitter and a receiver that work independently. Each one can run as clock master, shifted by an internal programmable baud-rate generator, or as a slave, shifted by an external clock. Data is launched on the falling edge of the shift clock and captured on the rising edge. The shift clock is low when idle, and the data line is high when idle.

Software controls the block through a small register port. Reads are registered and appear on `reg_rdata` one cycle after `reg_rd`. The port gives access to:
- a transmit holding buffer;
- a receive buffer;
- a control register with the enables, interrupt enables, master/slave selects, the automatic-transmit bit and the clock-source select;
- a status register with sticky error flags;
- the baud-rate generator settings and its live down-counter.

In master mode the generator runs only while there is master work to do. That means a transmit word is in progress or waiting, or a master receiver is enabled and its buffer is not full. The shift clock seen at the pin therefore carries exactly sixteen rising edges per word.

Top module: `sync_serial_xcvr`

## Requirements
- R1: After reset, STAT (address 3) reads 0x0001, `tx_data` is 1, and `sclk_out`, `irq_tx` and `irq_rx` are 0. STAT has tx_empty in bit 0, rx_full in bit 1, underrun in bit 2 and overflow in bit 3.
- R2: A word written to TXBUF (address 0) leaves on `tx_data` MSB first. A receiver clocked by the same shift clock delivers that word unchanged in RXBUF (address 1).
- R3: BAUD (address 4) holds the enable in bit 15 and the reload value in bits 7:0. COUNT (address 5) reads the enable in bit 15 and the down-counter in bits 7:0. While the generator is disabled or idle, the counter holds the reload value. While the generator is disabled, `sclk_out` stays low.
- R4: The master shift clock has a period of 2×(reload+1) enables of the selected source. CTRL bit 7 picks `src_ce_b` when 1 and `src_ce_a` when 0. A source that never pulses freezes the clock.
- R5: CTRL bit 4 selects master clocking for the transmitter and bit 5 does the same for the receiver. A slave direction is shifted only by its external clock and never starts the internal generator. A master receiver runs the clock until its buffer fills, then stops it.
- R6: A completed received word sets rx_full. Reading RXBUF clears it. With the receive enable (CTRL bit 1) low, no word is received.
- R7: If a word completes while rx_full is set, it is discarded and the overflow flag is set. The flag stays set until STAT is written with bit 3 set. Writing a zero leaves it set.
- R8: Writing TXBUF while the transmitter is busy clears tx_empty, and loading that word into the shifter sets it again. With the transmit enable (CTRL bit 0) low, `tx_data` is held at 1.
- R9: With automatic transmit (CTRL bit 6) on, a waiting word is loaded on the very edge that ends the previous word. A word ending with the buffer empty sets the underrun flag, which is cleared by writing STAT bit 2 set. With automatic transmit off, no underrun is flagged.
- R10: `irq_tx` follows tx_empty gated by CTRL bit 2, and `irq_rx` follows rx_full gated by CTRL bit 3, each one cycle late.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_ce_a | input | 1 | First clock-enable source for the generator |
| src_ce_b | input | 1 | Second clock-enable source for the generator |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data |
| tx_data | output | 1 | Serial transmit data |
| sclk_out | output | 1 | Master shift clock |
| tx_sclk_ext | input | 1 | External shift clock for a slave transmitter |
| rx_data_in | input | 1 | Serial receive data |
| rx_sclk_ext | input | 1 | External shift clock for a slave receiver |
| irq_tx | output | 1 | Transmit interrupt |
| irq_rx | output | 1 | Receive interrupt |

## Verification
The assertions check these properties on every cycle:
- a disabled generator keeps its clock low;
- a disabled transmitter idles high;
- a full receive buffer keeps its flag and its word until it is read;
- the underrun and overflow flags stay set until a write of one clears them.

Only the bench scenarios can show the rest:
- that words arrive intact and MSB first;
- that the shift period follows the reload value and the selected source;
- that automatic transmit runs words back to back, and that an overflow keeps the older word;
- that slave directions respond only to the external clock.

// File: rtl/ssx_pkg.sv
package ssx_pkg;
  typedef enum logic [2:0] {
    A_TXBUF = 3'd0,
    A_RXBUF = 3'd1,
    A_CTRL  = 3'd2,
    A_STAT  = 3'd3,
    A_BAUD  = 3'd4,
    A_COUNT = 3'd5
  } ssx_reg_e;

  typedef struct packed {
    logic clk_sel;
    logic auto_tx;
    logic rx_master;
    logic tx_master;
    logic rx_ie;
    logic tx_ie;
    logic rx_en;
    logic tx_en;
  } ssx_ctrl_t;
endpackage

// File: rtl/ssx_edge_sync.sv
module ssx_edge_sync #(
  parameter bit RISE = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic ev
);
  logic [2:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[1:0], din};
  end

  generate
    if (RISE) begin : g_rise
      assign ev = sh[1] & ~sh[2];
    end else begin : g_fall
      assign ev = ~sh[1] & sh[2];
    end
  endgenerate
endmodule

// File: rtl/ssx_baud_gen.sv
module ssx_baud_gen #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce_a,
  input  logic             ce_b,
  input  logic             sel,
  input  logic             en,
  input  logic             run,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt,
  output logic             sclk,
  output logic             rise_ev,
  output logic             fall_ev
);
  logic ce, tick;

  assign ce      = sel ? ce_b : ce_a;
  assign tick    = en & run & ce & (cnt == '0);
  assign rise_ev = tick & ~sclk;
  assign fall_ev = tick & sclk;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (!(en && run)) begin
      cnt  <= reload;
      sclk <= 1'b0;
    end else if (ce) begin
      if (cnt == '0) begin
        cnt  <= reload;
        sclk <= ~sclk;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/ssx_tx.sv
module ssx_tx #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         auto_mode,
  input  logic         fall_ev,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic         txd,
  output logic         empty,
  output logic         busy,
  output logic [W-1:0] hold,
  output logic         unr_ev
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  shreg;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      txd    <= 1'b1;
      empty  <= 1'b1;
      busy   <= 1'b0;
      hold   <= '0;
      shreg  <= '0;
      cnt    <= '0;
      unr_ev <= 1'b0;
    end else begin
      unr_ev <= 1'b0;
      if (!en) begin
        busy <= 1'b0;
        txd  <= 1'b1;
        cnt  <= '0;
      end else if (busy && fall_ev) begin
        if (cnt > CW'(1)) begin
          shreg <= {shreg[W-2:0], 1'b0};
          txd   <= shreg[W-2];
          cnt   <= cnt - 1'b1;
        end else if (auto_mode && !empty) begin
          shreg <= hold;
          txd   <= hold[W-1];
          cnt   <= CW'(W);
          empty <= 1'b1;
        end else begin
          busy   <= 1'b0;
          txd    <= 1'b1;
          unr_ev <= auto_mode & empty;
        end
      end else if (!busy && !empty && fall_ev) begin
        shreg <= hold;
        txd   <= hold[W-1];
        cnt   <= CW'(W);
        busy  <= 1'b1;
        empty <= 1'b1;
      end

      if (wr) begin
        hold <= wdata;
        if (en && !busy && empty) begin
          shreg <= wdata;
          txd   <= wdata[W-1];
          cnt   <= CW'(W);
          busy  <= 1'b1;
        end else begin
          empty <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/ssx_rx.sv
module ssx_rx #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         rise_ev,
  input  logic         rxd,
  input  logic         rd_clr,
  output logic [W-1:0] data,
  output logic         full,
  output logic         ovf_ev
);
  localparam int CW = $clog2(W);

  logic [W-2:0]  shreg;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      data   <= '0;
      full   <= 1'b0;
      ovf_ev <= 1'b0;
      shreg  <= '0;
      cnt    <= '0;
    end else begin
      ovf_ev <= 1'b0;
      if (rd_clr) full <= 1'b0;
      if (!en) begin
        cnt <= '0;
      end else if (rise_ev) begin
        if (cnt == CW'(W - 1)) begin
          cnt <= '0;
          if (full && !rd_clr) begin
            ovf_ev <= 1'b1;
          end else begin
            data <= {shreg, rxd};
            full <= 1'b1;
          end
        end else begin
          shreg <= {shreg[W-3:0], rxd};
          cnt   <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sync_serial_xcvr.sv
module sync_serial_xcvr
  import ssx_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              src_ce_a,
  input  logic              src_ce_b,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              tx_data,
  output logic              sclk_out,
  input  logic              tx_sclk_ext,
  input  logic              rx_data_in,
  input  logic              rx_sclk_ext,
  output logic              irq_tx,
  output logic              irq_rx
);
  localparam int PAD_W = WORD_W - 1 - CNT_W;

  ssx_ctrl_t         ctrl;
  logic              baud_en, unr, ovf;
  logic [CNT_W-1:0]  reload, bg_cnt;
  logic              bg_rise, bg_fall, ext_fall, ext_rise;
  logic              tx_empty, tx_busy, unr_ev, rx_full, ovf_ev, run;
  logic [WORD_W-1:0] tx_hold, rx_word, rd_mux;
  logic              wr_tx, rd_rx, wr_stat;

  assign wr_tx   = reg_wr && (reg_addr == A_TXBUF);
  assign rd_rx   = reg_rd && (reg_addr == A_RXBUF);
  assign wr_stat = reg_wr && (reg_addr == A_STAT);
  assign run     = (ctrl.tx_master & ctrl.tx_en & (tx_busy | ~tx_empty))
                 | (ctrl.rx_master & ctrl.rx_en & ~rx_full);

  ssx_baud_gen #(.CNT_W(CNT_W)) u_bg (
    .clk(clk), .rst(rst), .ce_a(src_ce_a), .ce_b(src_ce_b), .sel(ctrl.clk_sel),
    .en(baud_en), .run(run), .reload(reload), .cnt(bg_cnt), .sclk(sclk_out),
    .rise_ev(bg_rise), .fall_ev(bg_fall)
  );

  ssx_edge_sync #(.RISE(1'b0)) u_tx_sync (
    .clk(clk), .rst(rst), .din(tx_sclk_ext), .ev(ext_fall)
  );

  ssx_edge_sync #(.RISE(1'b1)) u_rx_sync (
    .clk(clk), .rst(rst), .din(rx_sclk_ext), .ev(ext_rise)
  );

  ssx_tx #(.W(WORD_W)) u_tx (
    .clk(clk), .rst(rst), .en(ctrl.tx_en), .auto_mode(ctrl.auto_tx),
    .fall_ev(ctrl.tx_master ? bg_fall : ext_fall), .wr(wr_tx), .wdata(reg_wdata),
    .txd(tx_data), .empty(tx_empty), .busy(tx_busy), .hold(tx_hold), .unr_ev(unr_ev)
  );

  ssx_rx #(.W(WORD_W)) u_rx (
    .clk(clk), .rst(rst), .en(ctrl.rx_en),
    .rise_ev(ctrl.rx_master ? bg_rise : ext_rise), .rxd(rx_data_in),
    .rd_clr(rd_rx), .data(rx_word), .full(rx_full), .ovf_ev(ovf_ev)
  );

  always_comb begin
    case (reg_addr)
      A_TXBUF: rd_mux = tx_hold;
      A_RXBUF: rd_mux = rx_word;
      A_CTRL:  rd_mux = {{(WORD_W-8){1'b0}}, ctrl};
      A_STAT:  rd_mux = {{(WORD_W-4){1'b0}}, ovf, unr, rx_full, tx_empty};
      A_BAUD:  rd_mux = {baud_en, {PAD_W{1'b0}}, reload};
      A_COUNT: rd_mux = {baud_en, {PAD_W{1'b0}}, bg_cnt};
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl      <= '0;
      baud_en   <= 1'b0;
      reload    <= '0;
      unr       <= 1'b0;
      ovf       <= 1'b0;
      irq_tx    <= 1'b0;
      irq_rx    <= 1'b0;
      reg_rdata <= '0;
    end else begin
      if (reg_wr && (reg_addr == A_CTRL)) ctrl <= ssx_ctrl_t'(reg_wdata[7:0]);
      if (reg_wr && (reg_addr == A_BAUD)) begin
        baud_en <= reg_wdata[WORD_W-1];
        reload  <= reg_wdata[CNT_W-1:0];
      end
      unr    <= (unr & ~(wr_stat & reg_wdata[2])) | unr_ev;
      ovf    <= (ovf & ~(wr_stat & reg_wdata[3])) | ovf_ev;
      irq_tx <= ctrl.tx_ie & tx_empty;
      irq_rx <= ctrl.rx_ie & rx_full;
      if (reg_rd) reg_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/ssx_checker.sv
module ssx_checker #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [2:0]        reg_addr,
  input logic [WORD_W-1:0] reg_wdata,
  input logic              baud_en,
  input logic              sclk_out,
  input logic              tx_en,
  input logic              tx_data,
  input logic              rx_full,
  input logic              ovf,
  input logic              unr,
  input logic [WORD_W-1:0] rxbuf
);
  logic rd_rx, clr_ovf, clr_unr;

  assign rd_rx   = reg_rd && (reg_addr == 3'd1);
  assign clr_ovf = reg_wr && (reg_addr == 3'd3) && reg_wdata[3];
  assign clr_unr = reg_wr && (reg_addr == 3'd3) && reg_wdata[2];

  a_r3_clock_parked: assert property (@(posedge clk) disable iff (rst)
    !baud_en |=> !sclk_out);

  a_r8_idle_high: assert property (@(posedge clk) disable iff (rst)
    !tx_en |=> tx_data);

  a_r6_full_holds: assert property (@(posedge clk) disable iff (rst)
    (rx_full && !rd_rx) |=> rx_full);

  a_r7_word_kept: assert property (@(posedge clk) disable iff (rst)
    (rx_full && !rd_rx) |=> $stable(rxbuf));

  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovf && !clr_ovf) |=> ovf);

  a_r9_unr_sticky: assert property (@(posedge clk) disable iff (rst)
    (unr && !clr_unr) |=> unr);
endmodule

bind sync_serial_xcvr ssx_checker #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .baud_en(baud_en), .sclk_out(sclk_out), .tx_en(ctrl.tx_en),
  .tx_data(tx_data), .rx_full(rx_full), .ovf(ovf), .unr(unr), .rxbuf(rx_word)
);

// File: tb/sync_serial_xcvr_tb.sv
`timescale 1ns/1ps
module sync_serial_xcvr_tb;
  logic        clk = 1'b0, rst = 1'b1;
  logic        ce_a = 1'b1, ce_b = 1'b0, ce_b_run = 1'b0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [15:0] wdata = 16'h0, rdata;
  logic        tx_data, sclk_out, irq_tx, irq_rx;
  logic        ext_clk = 1'b0, use_ext = 1'b0;
  logic        rx_clk_mux;
  int          checks = 0, errors = 0;

  localparam logic [15:0] VEC [6] = '{16'hA5C3, 16'h0001, 16'h8000,
                                      16'hFFFF, 16'h0000, 16'h1234};

  assign rx_clk_mux = use_ext ? ext_clk : sclk_out;

  always #2 clk = ~clk;
  always @(posedge clk) ce_b <= ce_b_run ? ~ce_b : 1'b0;

  sync_serial_xcvr u_dut (
    .clk(clk), .rst(rst), .src_ce_a(ce_a), .src_ce_b(ce_b),
    .reg_wr(wr), .reg_rd(rd), .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata),
    .tx_data(tx_data), .sclk_out(sclk_out), .tx_sclk_ext(ext_clk),
    .rx_data_in(tx_data), .rx_sclk_ext(rx_clk_mux), .irq_tx(irq_tx), .irq_rx(irq_rx)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_full();
    logic [15:0] s;
    for (int i = 0; i < 3000; i++) begin
      rd_reg(3'd3, s);
      if (s[1]) break;
    end
  endtask

  task automatic period(output int cyc);
    time t1, t2;
    @(posedge sclk_out); t1 = $time;
    @(posedge sclk_out); t2 = $time;
    cyc = int'((t2 - t1) / 4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d;
    int p;
    wait_cyc(5);
    rst = 1'b0;
    wait_cyc(2);
    // R1 reset state
    chk("R1 tx_data", {15'd0, tx_data}, 16'h1);
    chk("R1 sclk_out", {15'd0, sclk_out}, 16'h0);
    chk("R1 irqs", {14'd0, irq_tx, irq_rx}, 16'h0);
    rd_reg(3'd3, d); chk("R1 stat", d, 16'h0001);
    rd_reg(3'd5, d); chk("R3 count reset", d, 16'h0000);
    // R3 generator disabled / enabled idle
    wr_reg(3'd4, 16'h0007);
    rd_reg(3'd5, d); chk("R3 count disabled", d, 16'h0007);
    wr_reg(3'd4, 16'h8007);
    rd_reg(3'd5, d); chk("R3 count idle", d, 16'h8007);

    // R2 loopback vector walk: tx master, rx slave on sclk_out
    wr_reg(3'd2, 16'h0013);
    for (int i = 0; i < 6; i++) begin
      wr_reg(3'd0, VEC[i]);
      wait_full();
      rd_reg(3'd1, d); chk("R2 loopback word", d, VEC[i]);
      wait_cyc(20);
      rd_reg(3'd3, d); chk("R6 R9 stat after word", d, 16'h0001);
    end

    // R4 rate and source select
    wr_reg(3'd2, 16'h0011);
    wr_reg(3'd4, 16'h8003);
    wr_reg(3'd0, 16'h5555);
    period(p); chk("R4 period src a", 16'(p), 16'd8);
    wait_cyc(300);
    wr_reg(3'd2, 16'h0091);
    wr_reg(3'd0, 16'h5555);
    wait_cyc(100);
    chk("R4 frozen source", {15'd0, sclk_out}, 16'h0);
    ce_b_run = 1'b1;
    period(p); chk("R4 period src b", 16'(p), 16'd16);
    wait_cyc(600);
    ce_b_run = 1'b0;
    wr_reg(3'd4, 16'h8007);

    // R9 automatic transmit, R8 empty flag
    wr_reg(3'd2, 16'h0053);
    wr_reg(3'd0, 16'h0F0F);
    wr_reg(3'd0, 16'hF00D);
    rd_reg(3'd3, d); chk("R8 empty cleared", d, 16'h0000);
    wait_full();
    rd_reg(3'd1, d); chk("R9 auto word1", d, 16'h0F0F);
    wait_full();
    rd_reg(3'd1, d); chk("R9 auto word2", d, 16'hF00D);
    wait_cyc(40);
    rd_reg(3'd3, d); chk("R9 underrun set", d, 16'h0005);
    wr_reg(3'd3, 16'h0004);
    rd_reg(3'd3, d); chk("R9 underrun cleared", d, 16'h0001);

    // R7 overflow
    wr_reg(3'd2, 16'h0013);
    wr_reg(3'd0, 16'h1111);
    wait_full();
    wait_cyc(20);
    wr_reg(3'd0, 16'h2222);
    wait_cyc(400);
    rd_reg(3'd3, d); chk("R7 overflow set", d, 16'h000B);
    rd_reg(3'd1, d); chk("R7 older word kept", d, 16'h1111);
    wr_reg(3'd3, 16'h0000);
    rd_reg(3'd3, d); chk("R7 zero write keeps flag", d, 16'h0009);
    wr_reg(3'd3, 16'h0008);
    rd_reg(3'd3, d); chk("R7 overflow cleared", d, 16'h0001);

    // R6 receiver disabled
    wr_reg(3'd2, 16'h0011);
    wr_reg(3'd0, 16'h3333);
    wait_cyc(400);
    rd_reg(3'd3, d); chk("R6 rx disabled", d, 16'h0001);

    // R8 transmitter disabled
    wr_reg(3'd2, 16'h0000);
    wr_reg(3'd0, 16'h0000);
    wait_cyc(50);
    chk("R8 tx idle high", {15'd0, tx_data}, 16'h1);
    rd_reg(3'd0, d); chk("R8 word held", d, 16'h0000);
    wr_reg(3'd1, 16'h0000);
    rst = 1'b1; wait_cyc(3); rst = 1'b0; wait_cyc(2);
    wr_reg(3'd4, 16'h8007);

    // R5 slave mode on external clock
    use_ext = 1'b1;
    wr_reg(3'd2, 16'h0003);
    wr_reg(3'd0, 16'hC3A5);
    wait_cyc(20);
    chk("R5 slave no master clock", {15'd0, sclk_out}, 16'h0);
    for (int b = 0; b < 16; b++) begin
      ext_clk = 1'b1; wait_cyc(8);
      ext_clk = 1'b0; wait_cyc(8);
    end
    wait_cyc(10);
    rd_reg(3'd3, d); chk("R5 slave stat", d, 16'h0003);
    rd_reg(3'd1, d); chk("R5 slave word", d, 16'hC3A5);
    use_ext = 1'b0;

    // R5 master receiver stops when full
    wr_reg(3'd2, 16'h0022);
    wait_cyc(400);
    chk("R5 master rx clock stopped a", {15'd0, sclk_out}, 16'h0);
    wait_cyc(50);
    chk("R5 master rx clock stopped b", {15'd0, sclk_out}, 16'h0);
    rd_reg(3'd3, d); chk("R5 master rx full", d, 16'h0003);
    wr_reg(3'd2, 16'h0000);
    rd_reg(3'd1, d); chk("R5 master rx word", d, 16'hFFFF);

    // R10 interrupts
    wr_reg(3'd2, 16'h005F);
    wait_cyc(2);
    chk("R10 irq_tx empty", {15'd0, irq_tx}, 16'h1);
    chk("R10 irq_rx idle", {15'd0, irq_rx}, 16'h0);
    wr_reg(3'd0, 16'hBEEF);
    wr_reg(3'd0, 16'hCAFE);
    wait_cyc(2);
    chk("R10 irq_tx pending word", {15'd0, irq_tx}, 16'h0);
    wait_full();
    wait_cyc(1);
    chk("R10 irq_rx full", {15'd0, irq_rx}, 16'h1);
    rd_reg(3'd1, d); chk("R10 word1", d, 16'hBEEF);
    wait_cyc(2);
    chk("R10 irq_rx cleared", {15'd0, irq_rx}, 16'h0);
    wait_full();
    rd_reg(3'd1, d); chk("R10 word2", d, 16'hCAFE);
    wait_cyc(40);
    chk("R10 irq_tx after drain", {15'd0, irq_tx}, 16'h1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule